// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block turns a fast module clock into the timing enables that a serial shift engine needs. It does not make a new clock. It asserts a one-cycle tick at every half-period boundary of the serial clock. It also keeps a level output that flips on each tick, and that level serves as the reference waveform for the full serial clock period. The transfer engine shifts or samples on the ticks and drives its pin from the level.

The division comes from one configuration word that selects between two laws:

- The linear law gives a full period of 2×(N+1) module cycles, using an 8-bit count. Its largest division is 512.
- The power-of-two law gives a full period of 2^N module cycles, using a 4-bit exponent. It reaches much lower rates.

An exponent of zero selects bypass, where the engine runs at the module clock rate. The module clock must run at least twice as fast as the fastest serial rate requested.

The block latches a new configuration only while it is idle or at a half-period boundary. A half period that has already started always finishes with the setting it started with, so the serial clock never produces a runt pulse.

Top module: `spi_clk_div`

## Requirements
- R1: With the law bit `div_cfg_i[12]`=1 (linear), the half period is N+1 module cycles, where N=`div_cfg_i[7:0]`. `half_tick_o` pulses once every N+1 cycles while `run_i` is high.
- R2: With the law bit at 0 (power of two) and an exponent E=`div_cfg_i[11:8]` of at least 1, the half period is 2^(E-1) module cycles.
- R3: The law bit alone picks which field is used. The field that is not selected has no effect on the tick spacing.
- R4: With the law bit at 0 and E=0 (bypass), `half_tick_o` is high on every cycle while running and `sclk_ref_o` stays low.
- R5: While `run_i` is low, the counter is held cleared. One edge after `run_i` goes low, `half_tick_o` and `sclk_ref_o` are both low.
- R6: After `run_i` rises, the first tick appears after exactly one half period of enabled edges.
- R7: A configuration change made while running takes effect only at the next tick. The half period in progress completes with the old setting. This also applies when the change switches into bypass.
- R8: While `rst_ni` is low, `half_tick_o` and `sclk_ref_o` are low, whatever `run_i` and `div_cfg_i` are.
- R9: The extreme settings work: linear N=255 gives a half period of 256 (division 512), and exponent 15 gives a half period of 16384.
- R10: Outside bypass, `sclk_ref_o` starts low, flips on every tick and changes at no other time while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Divider runs while high; idle and cleared while low |
| div_cfg_i | input | 13 | Bits 7:0 linear count, bits 11:8 power-of-two exponent, bit 12 law select (1 linear) |
| half_tick_o | output | 1 | One-cycle pulse at each half-period boundary |
| sclk_ref_o | output | 1 | Serial clock reference level, flips on each tick |

## Verification
The hardest case to reach from the ports is a configuration change that lands in the middle of a half period. This matters most when the change moves into bypass, because the old count has to finish before the new setting is used. The stimulus waits for an observed tick, then writes the new word one cycle later, so the change falls at a known point inside the running count. The expected tick spacing is queued in advance, and it shows whether the old period completed intact. Two sequences cover this: a slowdown-to-speedup switch within the linear law, and a power-of-two setting that enters bypass.

// File: rtl/spi_clk_div_pkg.sv
package spi_clk_div_pkg;

   // Encoding of the law-select bit in the configuration word.
   typedef enum logic {
      LAW_POW2   = 1'b0,
      LAW_LINEAR = 1'b1
   } div_law_e;

endpackage

// File: rtl/spi_clk_div_cfg.sv
// Holds the divider setting in force and derives the half-period length.
module spi_clk_div_cfg
   import spi_clk_div_pkg::*;
#(
   parameter int LIN_W  = 8,
   parameter int POW_W  = 4,
   parameter int HALF_W = 15
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              law_i,
   input  logic [LIN_W-1:0]  lin_i,
   input  logic [POW_W-1:0]  pow_i,
   output logic [HALF_W-1:0] half_len_o,
   output logic              bypass_o
);

   div_law_e          law_q;
   logic [LIN_W-1:0]  lin_q;
   logic [POW_W-1:0]  pow_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         law_q <= LAW_LINEAR;
         lin_q <= '0;
         pow_q <= '0;
      end else if (load_i) begin
         law_q <= div_law_e'(law_i);
         lin_q <= lin_i;
         pow_q <= pow_i;
      end
   end

   assign bypass_o = (law_q == LAW_POW2) && (pow_q == '0);

   always_comb begin
      if (law_q == LAW_LINEAR) begin
         half_len_o = HALF_W'(lin_q) + HALF_W'(1);
      end else if (pow_q == '0) begin
         half_len_o = HALF_W'(1);
      end else begin
         half_len_o = HALF_W'(1) << (pow_q - POW_W'(1));
      end
   end

   // R7: the active setting only moves when a load is granted
   assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> ($stable(law_q) && $stable(lin_q) && $stable(pow_q)));

endmodule

// File: rtl/spi_clk_div_count.sv
// Half-period counter; produces the boundary strobe and the registered tick.
module spi_clk_div_count #(
   parameter int HALF_W = 15
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic [HALF_W-1:0] half_len_i,
   input  logic              bypass_i,
   output logic              wrap_o,
   output logic              tick_o
);

   logic [HALF_W-1:0] cnt_q;

   assign wrap_o = run_i && (bypass_i || (cnt_q == half_len_i - HALF_W'(1)));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= wrap_o;
         if (!run_i || wrap_o) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + HALF_W'(1);
         end
      end
   end

   // R1: the count never runs past the active half period
   assert_cnt_below_half_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < half_len_i);

   // R5: an idle cycle yields no tick
   assert_idle_no_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> !tick_o);

endmodule

// File: rtl/spi_clk_div_phase.sv
// Serial clock reference level: flips at each boundary, parked low otherwise.
module spi_clk_div_phase (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic wrap_i,
   input  logic bypass_i,
   output logic sclk_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sclk_o <= 1'b0;
      end else if (!run_i || bypass_i) begin
         sclk_o <= 1'b0;
      end else if (wrap_i) begin
         sclk_o <= ~sclk_o;
      end
   end

   // R5: level returns low one edge after the divider stops
   assert_idle_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> !sclk_o);

endmodule

// File: rtl/spi_clk_div.sv
// Dual-law serial clock divider top.
module spi_clk_div #(
   parameter int LIN_W = 8,
   parameter int POW_W = 4,
   localparam int LAW_BIT  = LIN_W + POW_W,
   localparam int CFG_W    = LAW_BIT + 1,
   localparam int POW_HALF = (1 << POW_W) - 1,
   localparam int HALF_W   = (LIN_W + 1 > POW_HALF) ? LIN_W + 1 : POW_HALF
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CFG_W-1:0] div_cfg_i,
   output logic             half_tick_o,
   output logic             sclk_ref_o
);

   generate
      if (LIN_W < 1 || LIN_W > 24) begin : g_bad_lin
         $error("spi_clk_div: LIN_W must be in 1..24");
      end
      if (POW_W < 1 || POW_W > 5) begin : g_bad_pow
         $error("spi_clk_div: POW_W must be in 1..5");
      end
   endgenerate

   logic [HALF_W-1:0] half_len;
   logic              bypass;
   logic              wrap;
   logic              load;

   // Accept new settings while idle or on a half-period boundary.
   assign load = !run_i || wrap;

   spi_clk_div_cfg #(
      .LIN_W  (LIN_W),
      .POW_W  (POW_W),
      .HALF_W (HALF_W)
   ) u_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .law_i      (div_cfg_i[LAW_BIT]),
      .lin_i      (div_cfg_i[LIN_W-1:0]),
      .pow_i      (div_cfg_i[LAW_BIT-1:LIN_W]),
      .half_len_o (half_len),
      .bypass_o   (bypass)
   );

   spi_clk_div_count #(
      .HALF_W (HALF_W)
   ) u_count (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_i),
      .half_len_i (half_len),
      .bypass_i   (bypass),
      .wrap_o     (wrap),
      .tick_o     (half_tick_o)
   );

   spi_clk_div_phase u_phase (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_i),
      .wrap_i   (wrap),
      .bypass_i (bypass),
      .sclk_o   (sclk_ref_o)
   );

   // R4: in bypass every running cycle carries a tick
   assert_bypass_every_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bypass && run_i) |=> half_tick_o);

   // R10: while running, the reference level only moves together with a tick
   assert_sclk_only_on_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(run_i) && !half_tick_o) |-> $stable(sclk_ref_o));

endmodule

// File: tb/tb_spi_clk_div.sv
module tb_spi_clk_div;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [12:0] cfg = '0;
   logic        tick;
   logic        sclk;

   always #5 clk = ~clk;

   spi_clk_div dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .run_i       (run),
      .div_cfg_i   (cfg),
      .half_tick_o (tick),
      .sclk_ref_o  (sclk)
   );

   int checks = 0;
   int fails  = 0;

   typedef struct {
      int    gap;
      bit    lvl;
      string req;
   } exp_t;

   exp_t exp_q[$];

   task automatic check(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic logic [12:0] mk(bit law, int pw, int ln);
      return {law, 4'(pw), 8'(ln)};
   endfunction

   task automatic push(int g, bit l, string rq);
      exp_t e;
      e.gap = g;
      e.lvl = l;
      e.req = rq;
      exp_q.push_back(e);
   endtask

   // Monitor: measures tick spacing from run start or the previous tick.
   int gap = 0;
   bit last_lvl = 1'b0;
   always @(posedge clk) begin
      bit r;
      exp_t e;
      r = run;
      #2;
      if (!rst_n) begin
         gap = 0;
      end else if (!r) begin
         gap = 0;
         check(tick == 1'b0, "R5", "tick while idle", int'(tick), 0);
         check(sclk == 1'b0, "R5", "sclk while idle", int'(sclk), 0);
      end else begin
         gap++;
         if (tick) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R1", "unexpected tick", gap, 0);
            end else begin
               e = exp_q.pop_front();
               check(gap == e.gap, e.req, "tick spacing", gap, e.gap);
               check(sclk == e.lvl, e.req, "sclk level at tick", int'(sclk), int'(e.lvl));
            end
            gap = 0;
         end else begin
            check(sclk == last_lvl, "R10", "sclk moved without tick", int'(sclk), int'(last_lvl));
         end
      end
      last_lvl = sclk;
   end

   // Driver: steady run with a fixed setting for n half periods.
   task automatic run_steady(logic [12:0] c, int half, int n, string rq, bit byp);
      @(negedge clk);
      cfg = c;
      @(negedge clk);
      run = 1'b1;
      for (int i = 0; i < n; i++) begin
         push(half, byp ? 1'b0 : ((i % 2) == 0), (i == 0) ? "R6" : rq);
      end
      repeat (n * half) @(negedge clk);
      run = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      finish_run();
   end

   initial begin
      // R8: reset dominates even with run and bypass requested
      run = 1'b1;
      cfg = mk(1'b0, 0, 0);
      repeat (3) begin
         @(negedge clk);
         check(tick == 1'b0, "R8", "tick in reset", int'(tick), 0);
         check(sclk == 1'b0, "R8", "sclk in reset", int'(sclk), 0);
      end
      run = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(tick == 1'b0, "R8", "tick after reset", int'(tick), 0);
      check(sclk == 1'b0, "R8", "sclk after reset", int'(sclk), 0);

      // R1: linear law
      run_steady(mk(1'b1, 0, 0), 1, 4, "R1", 1'b0);
      run_steady(mk(1'b1, 0, 3), 4, 4, "R1", 1'b0);
      run_steady(mk(1'b1, 9, 6), 7, 3, "R1", 1'b0);

      // R2: power-of-two law
      run_steady(mk(1'b0, 1, 200), 1, 4, "R2", 1'b0);
      run_steady(mk(1'b0, 2, 0), 2, 4, "R2", 1'b0);
      run_steady(mk(1'b0, 5, 77), 16, 3, "R2", 1'b0);

      // R3: same fields, law bit flips the result
      run_steady(mk(1'b1, 3, 5), 6, 2, "R3", 1'b0);
      run_steady(mk(1'b0, 3, 5), 4, 2, "R3", 1'b0);

      // R4: bypass, linear field ignored
      run_steady(mk(1'b0, 0, 42), 1, 5, "R4", 1'b1);

      // R9: extremes
      run_steady(mk(1'b1, 0, 255), 256, 2, "R9", 1'b0);
      run_steady(mk(1'b0, 15, 0), 16384, 2, "R9", 1'b0);

      // R7: linear half 4 -> half 1, changed one cycle after the first tick
      @(negedge clk);
      cfg = mk(1'b1, 0, 3);
      @(negedge clk);
      run = 1'b1;
      push(4, 1'b1, "R7");
      push(4, 1'b0, "R7");
      push(1, 1'b1, "R7");
      push(1, 1'b0, "R7");
      push(1, 1'b1, "R7");
      repeat (5) @(negedge clk);
      cfg = mk(1'b1, 0, 0);
      repeat (6) @(negedge clk);
      run = 1'b0;
      repeat (3) @(negedge clk);

      // R7: power-of-two half 2 -> bypass mid-period
      cfg = mk(1'b0, 2, 0);
      @(negedge clk);
      run = 1'b1;
      push(2, 1'b1, "R7");
      push(2, 1'b0, "R7");
      push(1, 1'b0, "R7");
      push(1, 1'b0, "R7");
      push(1, 1'b0, "R7");
      repeat (3) @(negedge clk);
      cfg = mk(1'b0, 0, 0);
      repeat (4) @(negedge clk);
      run = 1'b0;
      repeat (4) @(negedge clk);

      check(exp_q.size() == 0, "R7", "expected ticks left unseen", exp_q.size(), 0);
      finish_run();
   end

endmodule